// File: doc/BRIEF.md
# Display-Identification RAM Clear and Checksum Controller

This block owns the 768-byte table that a display sink presents on its identification bus. The table is split into six 128-byte blocks. Right after reset the controller wipes every byte to zero on its own. Only after that does it let the host load an image through a read/write port.

When the host raises the start input, the controller walks the six blocks in ascending order, one byte per clock. For each block it computes the byte that makes the whole block sum to zero modulo 256 and writes it into the block's last byte. A separate read-only port serves the identification bus. The hot-plug permission output stays low until a full checksum pass has finished, so the sink is never announced with a half-written table.

While the controller is clearing or summing, it owns the RAM and stalls the host. The host sees this as a low ready signal.

Top module: `edid_cksum_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, `busy` is high. The controller writes zero to all 768 bytes, one per clock. `busy` is first seen low after the 768th rising edge following reset release. After that, every address reads 0x00.
- R2: While `busy` is high, `host_ready` is low and host writes are dropped. A write issued then leaves the addressed byte unchanged.
- R3: A rising edge of `start` (sampled high at a clock edge after being low at the previous one) while idle begins a pass at that same edge, so `busy` reads high before the next edge. Holding `start` high does not begin another pass.
- R4: After a pass, byte 128·b+127 of each block b (addresses 0x07F, 0x0FF, 0x17F, 0x1FF, 0x27F, 0x2FF) holds the two's complement of the 8-bit sum of bytes 128·b to 128·b+126.
- R5: A pass changes no byte other than the six checksum bytes.
- R6: A pass reads one byte per clock in ascending address order and keeps `busy` high for exactly 768 clock cycles. The checksum of block b is written at the end of pass cycle 128·b+127, so block 0 is complete before block 1 is touched.
- R7: `done` is low after reset and is cleared when a pass begins. It rises when the last checksum has been written. `hpd_allow` equals `done`, so it is never high while `busy` is high.
- R8: A rising edge of `start` that arrives while `busy` is high is remembered. Exactly one further pass begins on the cycle after the current operation ends.
- R9: A host write accepted in the same cycle that a start edge is seen takes effect before the pass reads that address. The new checksum therefore includes it.
- R10: Host reads and identification-bus reads return the addressed byte one clock after the address is presented. The identification-bus port cannot write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Checksum pass request, rising-edge sensitive |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write when high |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the request |
| host_ready | output | 1 | Host access accepted this cycle |
| ddc_addr | input | 10 | Identification-bus read address |
| ddc_rdata | output | 8 | Identification-bus read data, one cycle later |
| busy | output | 1 | Clear or checksum pass in progress |
| done | output | 1 | Last checksum pass completed |
| hpd_allow | output | 1 | Hot-plug assertion permitted |

## Verification
A host write and the start of a checksum pass can fall in the same clock edge. Both then compete for the single RAM write port.

The bench provokes this by raising `start` and presenting a write into block 2 in the same cycle while the controller is idle. It then reads the whole table over the identification port. The check passes only if the written byte is present and block 2's checksum accounts for it.

A second collision is a start edge arriving mid-pass. It is judged by watching `busy` drop for exactly one cycle and then rise again for a second full pass.

// File: rtl/edid_pkg.sv
// Package: shared types for the identification-RAM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package edid_pkg;

    // Sequencer phases: power-up wipe, waiting, checksum walk.
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SUM   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/edid_ram.sv
// Module: edid_ram
// Two-port byte RAM. Port A reads and writes, with read-before-write
// and a one-cycle registered read. Port B is a registered read-only port.
// Assumes: one writer (port A); contents are undefined until cleared.
module edid_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 768,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Port A: optional write plus registered read of the old value.
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        a_rdata <= mem[a_addr];
    end

    // Port B: registered read for the identification bus.
    always_ff @(posedge clk) begin
        b_rdata <= mem[b_addr];
    end

endmodule

// File: rtl/edid_seq.sv
// Module: edid_seq
// Clear sequencer and checksum engine. After reset it writes zero to every
// byte. On a start edge it walks the blocks in ascending order, one read
// per clock, and writes each block's zero-sum byte on the block's last cycle.
// Assumes: BLK_BYTES is a power of two; the RAM read port has one cycle of
// latency; the engine owns the RAM whenever busy is high.
module edid_seq
    import edid_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BLK_BYTES = 128,
    parameter int NUM_BLK   = 6,
    parameter int ADDR_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_we,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic [DATA_W-1:0] eng_rdata
);

    localparam int BLK_W = $clog2(BLK_BYTES);
    localparam int NB_W  = ADDR_W - BLK_W;
    localparam int DEPTH = NUM_BLK * BLK_BYTES;
    localparam logic [BLK_W-1:0]  IDX_LAST = BLK_W'(BLK_BYTES - 1);
    localparam logic [NB_W-1:0]   BLK_LAST = NB_W'(NUM_BLK - 1);
    localparam logic [ADDR_W-1:0] CLR_LAST = ADDR_W'(DEPTH - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] clr_q;
    logic [NB_W-1:0]   blk_q;
    logic [BLK_W-1:0]  idx_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] sum_all;
    logic              start_q;
    logic              pend_q;
    logic              done_q;
    logic              rise;
    logic              go;
    logic              blk_end;

    assign rise    = start & ~start_q;
    assign go      = (state_q == ST_IDLE) && (rise || pend_q);
    assign blk_end = (state_q == ST_SUM) && (idx_q == IDX_LAST);
    assign sum_all = acc_q + eng_rdata;

    // Remember the previous level of the start input.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    // Hold an edge that arrived while busy until the sequencer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= 1'b0;
        else if (go)   pend_q <= 1'b0;
        else if (rise) pend_q <= 1'b1;
    end

    // Phase control with the clear counter and the block/byte walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            clr_q   <= '0;
            blk_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (clr_q == CLR_LAST) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (go) begin
                        state_q <= ST_SUM;
                        blk_q   <= '0;
                        idx_q   <= '0;
                    end
                end
                ST_SUM: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_LAST) begin
                        if (blk_q == BLK_LAST) state_q <= ST_IDLE;
                        else                   blk_q   <= blk_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Running sum of the block; read data lags the address by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  acc_q <= '0;
        else if (state_q == ST_SUM) begin
            if (idx_q == '0)         acc_q <= '0;
            else                     acc_q <= sum_all;
        end
    end

    // Completion flag: cleared on start, set after the final checksum.
    always_ff @(posedge clk) begin
        if (!rst_n)                           done_q <= 1'b0;
        else if (go)                          done_q <= 1'b0;
        else if (blk_end && blk_q == BLK_LAST) done_q <= 1'b1;
    end

    // RAM request: zero fill while clearing, walk and checksum while summing.
    always_comb begin
        eng_addr  = '0;
        eng_we    = 1'b0;
        eng_wdata = '0;
        if (state_q == ST_CLEAR) begin
            eng_addr = clr_q;
            eng_we   = 1'b1;
        end else if (state_q == ST_SUM) begin
            eng_addr  = {blk_q, idx_q};
            eng_we    = blk_end;
            eng_wdata = {DATA_W{1'b0}} - sum_all;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/edid_port_mux.sv
// Module: edid_port_mux
// RAM port arbitration. The engine owns the read/write port while busy,
// and the host owns it otherwise.
// Assumes: busy comes from registered state, so the grant is stable
// for the whole cycle.
module edid_port_mux #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              eng_busy,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic              eng_we,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata
);

    // Choose the owner of the shared port for this cycle.
    always_comb begin
        host_ready = ~eng_busy;
        if (eng_busy) begin
            ram_addr  = eng_addr;
            ram_we    = eng_we;
            ram_wdata = eng_wdata;
        end else begin
            ram_addr  = host_addr;
            ram_we    = host_en & host_we;
            ram_wdata = host_wdata;
        end
    end

endmodule

// File: rtl/edid_cksum_ctrl.sv
// Module: edid_cksum_ctrl (top)
// Display-identification RAM with an automatic wipe after reset, a
// checksum pass on request, host access, a read-only identification
// port and a hot-plug permission output.
// Assumes: synchronous active-low reset; BLK_BYTES is a power of two.
module edid_cksum_ctrl #(
    parameter int DATA_W    = 8,
    parameter int BLK_BYTES = 128,
    parameter int NUM_BLK   = 6,
    parameter int ADDR_W    = $clog2(NUM_BLK) + $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    input  logic [ADDR_W-1:0] ddc_addr,
    output logic [DATA_W-1:0] ddc_rdata,
    output logic              busy,
    output logic              done,
    output logic              hpd_allow
);

    localparam int DEPTH = NUM_BLK * BLK_BYTES;

    logic [ADDR_W-1:0] eng_addr;
    logic              eng_we;
    logic [DATA_W-1:0] eng_wdata;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;

    edid_seq #(
        .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES),
        .NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done),
        .eng_addr(eng_addr), .eng_we(eng_we),
        .eng_wdata(eng_wdata), .eng_rdata(ram_rdata)
    );

    edid_port_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
        .eng_busy(busy), .eng_addr(eng_addr), .eng_we(eng_we),
        .eng_wdata(eng_wdata), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata)
    );

    edid_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .a_addr(ram_addr), .a_we(ram_we),
        .a_wdata(ram_wdata), .a_rdata(ram_rdata),
        .b_addr(ddc_addr), .b_rdata(ddc_rdata)
    );

    assign host_rdata = ram_rdata;
    assign hpd_allow  = done;

endmodule

// File: rtl/edid_cksum_ctrl_chk.sv
// Module: edid_cksum_ctrl_chk
// Protocol checker bound to the top. It covers the host stall, the start
// response, the pass and clear lengths, and the completion flags.
// Assumes: the same synchronous active-low reset as the design.
module edid_cksum_ctrl_chk #(
    parameter int PASS_LEN = 768
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic hpd_allow,
    input logic host_ready
);

    logic [15:0] busy_cnt;

    // Length of the current busy interval, in clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    assert_host_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_ready);

    assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !$past(start)) |=> busy);

    assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 16'(PASS_LEN)));

    assert_done_after_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_hpd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_allow |-> !busy);

endmodule

bind edid_cksum_ctrl edid_cksum_ctrl_chk #(.PASS_LEN(NUM_BLK * BLK_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .hpd_allow(hpd_allow), .host_ready(host_ready)
);

// File: tb/edid_cksum_ctrl_test.sv
`timescale 1ns/1ps
module edid_cksum_ctrl_test;

    localparam int DEPTH = 768;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       host_en = 1'b0;
    logic       host_we = 1'b0;
    logic [9:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic [9:0] ddc_addr = '0;
    logic [7:0] ddc_rdata;
    logic       busy;
    logic       done;
    logic       hpd_allow;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    edid_cksum_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .ddc_addr(ddc_addr), .ddc_rdata(ddc_rdata),
        .busy(busy), .done(done), .hpd_allow(hpd_allow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input int d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1;
        host_addr = 10'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output int d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = 10'(a);
        @(negedge clk);
        host_en = 1'b0;
        d = int'(host_rdata);
    endtask

    task automatic ddc_read(input int a, output int d);
        @(negedge clk);
        ddc_addr = 10'(a);
        @(negedge clk);
        d = int'(ddc_rdata);
    endtask

    function automatic logic [7:0] blk_cks(input int b);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 127; i++) s = s + model[b*128 + i];
        return 8'h00 - s;
    endfunction

    task automatic apply_cks();
        for (int b = 0; b < 6; b++) model[b*128 + 127] = blk_cks(b);
    endtask

    // Compare the full table, read over the identification port, with the model.
    task automatic scan(input string req);
        int errs = 0;
        int d;
        int bad_a = 0;
        int bad_d = 0;
        for (int a = 0; a < DEPTH; a++) begin
            ddc_read(a, d);
            if (d != int'(model[a])) begin
                if (errs == 0) begin bad_a = a; bad_d = d; end
                errs++;
            end
        end
        check(req, (errs == 0) ? 0 : bad_d,
              (errs == 0) ? 0 : int'(model[bad_a]));
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        check(req, int'(busy), 0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R1, R2, R7: wipe after reset, host stalled meanwhile, flags low.
    task automatic t_reset_clear();
        int cnt = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 busy in reset", int'(busy), 1);
        check("R7 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cnt = 1;
        check("R2 ready low while clearing", int'(host_ready), 0);
        host_en = 1'b1; host_we = 1'b1; host_addr = 10'd3; host_wdata = 8'hEE;
        @(negedge clk);
        cnt++;
        host_en = 1'b0; host_we = 1'b0;
        while (busy && cnt < 2000) begin @(negedge clk); cnt++; end
        check("R1 clear length", cnt, 768);
        check("R7 hpd after clear", int'(hpd_allow), 0);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        scan("R1/R2 table zero after clear");
    endtask

    // R3, R4, R5, R6, R7, R10: load image, run a pass, verify.
    task automatic t_load_and_sum();
        int d;
        int cnt = 0;
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = 8'((a * 37 + 11) ^ (a >> 3));
            host_write(a, int'(model[a]));
        end
        host_read(200, d);
        check("R10 host read", d, int'(model[200]));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        check("R3 busy after start edge", int'(busy), 1);
        check("R7 hpd low in pass", int'(hpd_allow), 0);
        start = 1'b0;
        cnt = 1;
        while (busy && cnt < 2000) begin @(negedge clk); if (busy) cnt++; end
        check("R6 pass length", cnt, 768);
        check("R7 done after pass", int'(done), 1);
        check("R7 hpd after pass", int'(hpd_allow), 1);
        apply_cks();
        scan("R4/R5 checksums and untouched bytes");
    endtask

    // R6, R4: ascending order seen mid-pass, then new checksums.
    task automatic t_rerun_order();
        int d;
        logic [7:0] old_b1;
        model[10]  = model[10] + 8'h21;
        model[140] = model[140] + 8'h05;
        host_write(10, int'(model[10]));
        host_write(140, int'(model[140]));
        old_b1 = model[255];
        pulse_start();
        check("R7 done cleared at start", int'(done), 0);
        repeat (160) @(negedge clk);
        ddc_read(127, d);
        check("R6 block0 written first", d, int'(blk_cks(0)));
        ddc_read(255, d);
        check("R6 block1 not yet written", d, int'(old_b1));
        wait_idle("R6 pass ends");
        apply_cks();
        scan("R4 checksums after rerun");
    endtask

    // R8: an edge during a pass gives exactly one extra pass.
    task automatic t_pending();
        int n = 0;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check("R8 first pass done", int'(busy), 0);
        @(negedge clk);
        check("R8 second pass begins", int'(busy), 1);
        wait_idle("R8 second pass ends");
        repeat (5) @(negedge clk);
        check("R8 no third pass", int'(busy), 0);
        check("R8 done after second pass", int'(done), 1);
    endtask

    // R9: host write in the same cycle as the start edge.
    task automatic t_coincide();
        @(negedge clk);
        check("R9 ready at collision", int'(host_ready), 1);
        start = 1'b1;
        host_en = 1'b1; host_we = 1'b1; host_addr = 10'h105; host_wdata = 8'h9C;
        @(negedge clk);
        start = 1'b0; host_en = 1'b0; host_we = 1'b0;
        model[10'h105] = 8'h9C;
        wait_idle("R9 pass ends");
        apply_cks();
        scan("R9 collided write included in checksum");
    endtask

    // R3: a held level does not start another pass.
    task automatic t_level();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        wait_idle("R3 level pass ends");
        repeat (30) @(negedge clk);
        check("R3 held level no retrigger", int'(busy), 0);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_clear();
        t_load_and_sum();
        t_rerun_order();
        t_pending();
        t_coincide();
        t_level();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule